// File: doc/BRIEF.md
# Self-Synchronizing Test Pattern Checker with Saturating Error Counter

This block sits on the receive side of a serial link under test. The far end sends a scrambled stream of all-zero data through a 58-stage self-synchronizing scrambler. The checker shifts every received bit into a history register of its own. From that history it predicts each new bit, so it needs no seed and no link to the local pattern generator. Generation and checking can therefore run at the same time over a loopback.

A lock tracker declares the link synchronized once it has seen a long run of correct predictions. It withdraws that state when errors become dense. Isolated errors, which are expected in a stressed link, leave the lock alone.

While the link is synchronized, each wrong prediction increments an 8-bit error count. The count sticks at its maximum value. Software can zero it to start a new measurement. A read strobe copies the live count into a shadow register and, in the same cycle, restarts the live count. This lets a reader take a consistent sample without losing any error.

Top module: `pattern_checker`

## Requirements
- R1: After reset, `in_sync` is 0, `err_count` is 0 and `err_shadow` is 0.
- R2: Each valid bit is predicted as the XOR of the valid bits received 39 and 58 positions before it. A bit that differs from its prediction is a mismatch. A single inverted line bit therefore produces three mismatches: at that bit, 39 bits later and 58 bits later.
- R3: `in_sync` rises only after 58 consecutive valid bits without a mismatch. It is therefore never 1 within the first 57 valid bits after reset. It is reacquired the same way after a loss.
- R4: While synchronized, 16 mismatches inside one aligned block of 64 valid bits clear `in_sync`. Sparser errors (a few per 64 bits) leave it set.
- R5: Mismatches are counted only when `in_sync` is 1 in the cycle of the bit. Mismatches seen while unsynchronized leave the count unchanged.
- R6: `err_count` increases by one per counted mismatch and holds at 255 instead of wrapping.
- R7: `cnt_clear` sets `err_count` to 0 on the next edge. It takes priority over a read and over a mismatch in the same cycle.
- R8: `cnt_read` loads `err_shadow` with the value `err_count` had in that cycle. `err_shadow` changes at no other time.
- R9: `cnt_read` without `cnt_clear` restarts `err_count`. The new value is 1 if a counted mismatch arrives in the read cycle, otherwise 0.
- R10: Cycles with `rx_valid` low change neither the history, the lock state nor the count, whatever `rx_bit` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Received line bit |
| rx_valid | input | 1 | `rx_bit` carries a bit this cycle |
| cnt_clear | input | 1 | Zero the error count |
| cnt_read | input | 1 | Copy the count to the shadow and restart it |
| in_sync | output | 1 | Checker is synchronized to the stream |
| err_count | output | 8 | Live saturating error count |
| err_shadow | output | 8 | Count captured at the last read |

## Verification
The hardest situation to reach is a read strobe that lands on the exact cycle of a counted error. The bench gets there by exploiting the fixed tap spacing. It inverts one line bit while locked, then sends exactly 57 clean bits and raises the read strobe on the 58th. That bit is the known third echo of the inversion, so the shadow must show 2 and the fresh count must show 1. Saturation is reached with echo triples spaced far enough apart that the lock survives. Loss of lock comes from a dense burst of inverted bits, which also leaves trailing echoes that must not be counted while the checker relocks.

// File: rtl/pchk_pkg.sv
package pchk_pkg;
  localparam int unsigned DEF_SR_LEN  = 58;
  localparam int unsigned DEF_TAP     = 39;
  localparam int unsigned DEF_CNT_W   = 8;

  // prediction from the history: bit received TAP ago XOR bit received LEN ago
  function automatic logic predict_bit(input logic tap_old, input logic len_old);
    return tap_old ^ len_old;
  endfunction

  // saturating increment against an all-ones ceiling
  function automatic logic [31:0] sat_step(input logic [31:0] cur, input logic [31:0] ceiling,
                                           input logic bump);
    if (!bump || cur >= ceiling) return cur;
    return cur + 32'd1;
  endfunction
endpackage

// File: rtl/pchk_descrambler.sv
module pchk_descrambler #(
  parameter int unsigned SR_LEN = pchk_pkg::DEF_SR_LEN,
  parameter int unsigned TAP    = pchk_pkg::DEF_TAP
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_bit,
  input  logic rx_valid,
  output logic mismatch
);
  logic [SR_LEN-1:0] hist;
  logic              expect_bit;

  assign expect_bit = pchk_pkg::predict_bit(hist[TAP-1], hist[SR_LEN-1]);
  assign mismatch   = rx_valid & (rx_bit ^ expect_bit);

  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (rx_valid) hist <= {hist[SR_LEN-2:0], rx_bit};
  end
endmodule

// File: rtl/pchk_lock.sv
module pchk_lock #(
  parameter int unsigned LOCK_RUN = 58,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned LOSS_CNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_valid,
  input  logic mismatch,
  output logic in_sync,
  output logic lock_evt,
  output logic loss_evt
);
  localparam int unsigned RUN_W  = $clog2(LOCK_RUN + 1);
  localparam int unsigned WIN_W  = $clog2(WIN_LEN);
  localparam int unsigned BAD_W  = $clog2(LOSS_CNT + 1);

  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] win;
  logic [BAD_W-1:0] bad;
  logic             win_end;

  assign lock_evt = rx_valid & ~in_sync & ~mismatch & (run == RUN_W'(LOCK_RUN - 1));
  assign loss_evt = rx_valid &  in_sync &  mismatch & (bad == BAD_W'(LOSS_CNT - 1));
  assign win_end  = (win == WIN_W'(WIN_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_sync <= 1'b0;
      run     <= '0;
      win     <= '0;
      bad     <= '0;
    end else if (rx_valid) begin
      if (!in_sync) begin
        win <= '0;
        bad <= '0;
        if (mismatch)      run <= '0;
        else if (lock_evt) begin
          run     <= '0;
          in_sync <= 1'b1;
        end else           run <= run + RUN_W'(1);
      end else begin
        run <= '0;
        if (loss_evt) begin
          in_sync <= 1'b0;
          win     <= '0;
          bad     <= '0;
        end else if (win_end) begin
          win <= '0;
          bad <= '0;
        end else begin
          win <= win + WIN_W'(1);
          bad <= bad + BAD_W'(mismatch);
        end
      end
    end
  end
endmodule

// File: rtl/pchk_errcnt.sv
module pchk_errcnt #(
  parameter int unsigned CNT_W = pchk_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err_evt,
  input  logic             cnt_clear,
  input  logic             cnt_read,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] shadow
);
  localparam logic [31:0] CEIL = 32'((64'd1 << CNT_W) - 64'd1);

  logic [31:0] stepped;
  assign stepped = pchk_pkg::sat_step(32'(count), CEIL, err_evt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= '0;
      shadow <= '0;
    end else begin
      if (cnt_read)       shadow <= count;
      if (cnt_clear)      count  <= '0;
      else if (cnt_read)  count  <= CNT_W'(err_evt);
      else                count  <= stepped[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pattern_checker.sv
module pattern_checker #(
  parameter int unsigned SR_LEN   = pchk_pkg::DEF_SR_LEN,
  parameter int unsigned TAP      = pchk_pkg::DEF_TAP,
  parameter int unsigned WIN_LEN  = 64,
  parameter int unsigned LOSS_CNT = 16,
  parameter int unsigned CNT_W    = pchk_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic             cnt_clear,
  input  logic             cnt_read,
  output logic             in_sync,
  output logic [CNT_W-1:0] err_count,
  output logic [CNT_W-1:0] err_shadow
);
  logic mismatch;
  logic err_evt;
  logic lock_evt;
  logic loss_evt;

  pchk_descrambler #(.SR_LEN(SR_LEN), .TAP(TAP)) u_desc (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid), .mismatch(mismatch)
  );

  pchk_lock #(.LOCK_RUN(SR_LEN), .WIN_LEN(WIN_LEN), .LOSS_CNT(LOSS_CNT)) u_lock (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .mismatch(mismatch),
    .in_sync(in_sync), .lock_evt(lock_evt), .loss_evt(loss_evt)
  );

  assign err_evt = mismatch & in_sync;

  pchk_errcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .cnt_clear(cnt_clear),
    .cnt_read(cnt_read), .count(err_count), .shadow(err_shadow)
  );
endmodule

// File: rtl/pattern_checker_sva.sv
module pattern_checker_sva #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             cnt_clear,
  input logic             cnt_read,
  input logic             in_sync,
  input logic             err_evt,
  input logic             lock_evt,
  input logic [CNT_W-1:0] err_count,
  input logic [CNT_W-1:0] err_shadow
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == TOP && !cnt_clear && !cnt_read) |=> err_count == TOP);
  assert_step_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_clear && !cnt_read && err_evt && err_count != TOP) |=> err_count == $past(err_count) + 1'b1);
  assert_unsynced_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_sync && !cnt_clear && !cnt_read) |=> $stable(err_count));
  assert_evt_needs_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> in_sync);
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> err_count == '0);
  assert_shadow_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_read |=> err_shadow == $past(err_count));
  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_read |=> $stable(err_shadow));
  assert_read_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_read && !cnt_clear) |=> err_count <= CNT_W'(1));
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !cnt_clear && !cnt_read) |=> ($stable(in_sync) && $stable(err_count)));
  assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> in_sync);
endmodule

bind pattern_checker pattern_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .cnt_clear(cnt_clear), .cnt_read(cnt_read),
  .in_sync(in_sync), .err_evt(err_evt), .lock_evt(lock_evt),
  .err_count(err_count), .err_shadow(err_shadow)
);

// File: tb/tb_pattern_checker.sv
module tb_pattern_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_bit = 1'b0, rx_valid = 1'b0, cnt_clear = 1'b0, cnt_read = 1'b0;
  logic       in_sync;
  logic [7:0] err_count, err_shadow;

  int  n_run = 0, n_fail = 0;
  bit  done = 1'b0;
  int  exp_q[$];
  logic [57:0] gen = 58'h0123456789ABCDE;

  always #5 clk = ~clk;

  pattern_checker dut (
    .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .cnt_clear(cnt_clear), .cnt_read(cnt_read),
    .in_sync(in_sync), .err_count(err_count), .err_shadow(err_shadow)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one valid line bit from the reference scrambler, optionally inverted
  task automatic step(input bit flip, input bit rd, input bit clr);
    logic b;
    b = gen[38] ^ gen[57];
    gen = {gen[56:0], b};
    rx_bit = b ^ flip; rx_valid = 1'b1; cnt_read = rd; cnt_clear = clr;
    @(negedge clk);
    rx_valid = 1'b0; cnt_read = 1'b0; cnt_clear = 1'b0;
  endtask

  task automatic clean(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic read_expect(input int e);
    exp_q.push_back(e);
    step(1'b0, 1'b1, 1'b0);
  endtask

  // monitor: compare the shadow after each read against the queued value (R8)
  initial begin
    forever begin
      @(posedge clk);
      if (cnt_read) begin
        @(negedge clk);
        #1;
        if (exp_q.size() == 0) chk("R8 unexpected read", 1, 0);
        else chk("R8 shadow", int'(err_shadow), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 sync", int'(in_sync), 0);
    chk("R1 count", int'(err_count), 0);
    chk("R1 shadow", int'(err_shadow), 0);
    rst_n = 1'b1;
    @(negedge clk);

    clean(57);
    chk("R3 no early lock", int'(in_sync), 0);
    clean(143);
    chk("R3 lock", int'(in_sync), 1);
    read_expect(0);

    // R2: one inverted bit echoes three times
    step(1'b1, 1'b0, 1'b0);
    clean(70);
    chk("R2 triple", int'(err_count), 3);
    read_expect(3);
    chk("R9 restart", int'(err_count), 0);

    // R9: read on the cycle of the third echo
    step(1'b1, 1'b0, 1'b0);
    clean(57);
    read_expect(2);
    chk("R9 fresh count", int'(err_count), 1);
    clean(5);
    read_expect(1);

    // R10: idle cycles with garbage on the data line
    for (int i = 0; i < 20; i++) begin
      rx_bit = i[0] ^ i[2]; rx_valid = 1'b0;
      @(negedge clk);
    end
    chk("R10 sync kept", int'(in_sync), 1);
    chk("R10 count", int'(err_count), 0);
    clean(80);
    chk("R10 history intact", int'(err_count), 0);

    // R7: clear
    step(1'b1, 1'b0, 1'b0);
    clean(70);
    chk("R7 before", int'(err_count), 3);
    step(1'b0, 1'b0, 1'b1);
    chk("R7 clear", int'(err_count), 0);

    // R6 / R4: sparse errors saturate without losing lock
    for (int k = 0; k < 90; k++) begin
      step(1'b1, 1'b0, 1'b0);
      clean(59);
    end
    chk("R6 saturate", int'(err_count), 255);
    chk("R4 sparse keeps lock", int'(in_sync), 1);
    read_expect(255);
    chk("R9 after sat", int'(err_count), 0);

    // R4: dense burst drops lock
    for (int k = 0; k < 39; k++) step(1'b1, 1'b0, 1'b0);
    chk("R4 loss", int'(in_sync), 0);
    step(1'b0, 1'b0, 1'b1);
    clean(200);
    chk("R3 relock", int'(in_sync), 1);
    read_expect(0);  // R5: echoes while unlocked not counted
    chk("R5 count", int'(err_count), 0);

    repeat (3) @(negedge clk);
    chk("R8 queue drained", exp_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule